// File: doc/BRIEF.md
# Serial Converter Result Frame Reader

This block is the host side of a link to a serial analog-to-digital converter that shows its readiness on its own data-out line. When `start` is pulsed, the reader lowers chip select and watches the converter's data line. A high level means a conversion is still running. A low level means a result is waiting. While the line stays high, chip select is lifted briefly and lowered again at a fixed rhythm. An overall timeout ends the attempt if readiness never shows.

Once readiness is seen, the reader drives 32 serial clock pulses, with the clock idling low. On each pulse it shifts a configuration word into the converter, most significant bit first, and captures one result bit on the rising edge. After the 32nd pulse it raises chip select, which lets the converter start its next conversion. It then presents the frame split into fields: a status flag, a sign, a 24-bit magnitude and five sub-resolution bits.

The result is a one-cycle strobe with no back-pressure. The consumer must take the fields in the cycle `res_valid` is high, because the next read can only begin after `busy` has dropped. The strobe is tied to the serial frame, and a stall input would only stretch chip select.

Top module: `adc_frame_reader`

## Requirements
- R1: During and right after reset, `cs_n` is 1, and `sclk`, `busy`, `res_valid` and `timeout_err` are 0.
- R2: A `start` seen while idle makes `cs_n` 0 and `busy` 1 in the next cycle. `start` has no effect while `busy` is high. Whenever `busy` is 0, `cs_n` is 1.
- R3: While the converter holds `miso` high, each chip-select-low window lasts POLL_LEN cycles and is followed by `cs_n` high for GAP_LEN cycles, then a new low window.
- R4: `miso` read as 0 with `cs_n` low, from the second cycle of a window on, starts the frame. A frame has exactly 32 rising `sclk` edges, and `sclk` is 0 whenever `cs_n` is 1.
- R5: Each high phase of `sclk` lasts SCLK_HALF system clock cycles.
- R6: `mosi` carries the `cfg_word` captured at `start`, MSB first, on the first CFG_W rising edges, and 0 on the remaining edges. `mosi` never changes in the cycle `sclk` rises.
- R7: `miso` is captured on each rising `sclk` edge, first bit as frame bit 31. The outputs are: `res_status` = bit 31, `res_sign` = bit 29, `res_value` = bits 28..5, `res_sub` = bits 4..0.
- R8: `res_frame_err` is 1 exactly when frame bit 30 (always 0 from a healthy converter) or frame bit 31 reads 1.
- R9: In the cycle after the 32nd falling `sclk` edge, `cs_n` is 1 and `res_valid` is high for one cycle. `busy` drops in the following cycle.
- R10: If readiness is not seen within TIMEOUT cycles after chip select first falls, `timeout_err` pulses for one cycle as `busy` falls and `cs_n` rises, with no `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a read when idle |
| cfg_word | input | CFG_W | Configuration word sent to the converter |
| busy | output | 1 | High from chip select falling until the read ends |
| cs_n | output | 1 | Converter chip select, active low |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data to the converter |
| miso | input | 1 | Serial data and readiness level from the converter |
| res_valid | output | 1 | One-cycle strobe for the result fields |
| res_status | output | 1 | Frame bit 31, end-of-conversion flag |
| res_sign | output | 1 | Frame bit 29, sign |
| res_value | output | 24 | Frame bits 28..5, result magnitude |
| res_sub | output | 5 | Frame bits 4..0, sub-resolution bits |
| res_frame_err | output | 1 | Dummy or status bit read as 1 |
| timeout_err | output | 1 | One-cycle pulse when readiness never appeared |

## Verification
The bench models a converter that becomes ready a set number of cycles after each frame. Readiness therefore lands in the second or later polling window, so a reader that got the window or gap length wrong shows a bad run length. One frame starts with the converter already ready, which catches a reader that needs a full window before it looks at the line. One case has the status bit flip to 1 after readiness was detected, and another has the dummy bit set. A reader that set its error from the poll level, or ignored either bit, would report a clean frame. A mid-frame `start` pulse and a never-ready converter expose a reader that restarts itself or loops forever, or one that lets the timeout and the result strobe overlap.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

  localparam int FRAME_W = 32;
  localparam int VAL_W   = 24;
  localparam int SUB_W   = 5;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_POLL  = 3'd1,
    ST_GAP   = 3'd2,
    ST_SHIFT = 3'd3,
    ST_DONE  = 3'd4
  } rd_state_e;

  // Field order follows arrival order on the wire: first bit is the MSB.
  typedef struct packed {
    logic             eoc;
    logic             dummy;
    logic             sign;
    logic [VAL_W-1:0] value;
    logic [SUB_W-1:0] sub;
  } frame_t;

endpackage

// File: rtl/adc_rd_sclk.sv
module adc_rd_sclk #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic sclk,
  output logic rise,
  output logic fall
);

  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q;
  logic          sclk_q;
  logic          wrap;

  assign wrap = run && (cnt_q == CW'(HALF - 1));
  assign rise = wrap && !sclk_q;
  assign fall = wrap && sclk_q;
  assign sclk = sclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (!run) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      sclk_q <= ~sclk_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R5: the level toggles only at the end of a full half period
  p_half_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !wrap && $past(run)) |=> $stable(sclk_q));

endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int FW    = 32,
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CFG_W-1:0] cfg,
  input  logic             rise,
  input  logic             fall,
  input  logic             miso,
  output logic             mosi,
  output logic [FW-1:0]    rx,
  output logic             last_fall
);

  localparam int NW = $clog2(FW + 1);

  logic [FW-1:0] tx_q;
  logic [FW-1:0] rx_q;
  logic [NW-1:0] nbit_q;

  assign mosi      = tx_q[FW-1];
  assign rx        = rx_q;
  assign last_fall = fall && (nbit_q == NW'(FW - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q   <= '0;
      rx_q   <= '0;
      nbit_q <= '0;
    end else begin
      if (load) begin
        tx_q   <= FW'(cfg) << (FW - CFG_W);
        nbit_q <= '0;
      end else if (fall) begin
        tx_q   <= tx_q << 1;
        nbit_q <= nbit_q + 1'b1;
      end
      if (rise) begin
        rx_q <= {rx_q[FW-2:0], miso};
      end
    end
  end

  // R4: no rising edge beyond the frame length
  p_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |-> (nbit_q < NW'(FW)));

endmodule

// File: rtl/adc_rd_unpack.sv
module adc_rd_unpack
  import adc_rd_pkg::*;
(
  input  logic [FRAME_W-1:0] frame,
  output logic               status,
  output logic               sign,
  output logic [VAL_W-1:0]   value,
  output logic [SUB_W-1:0]   sub,
  output logic               frame_err
);

  frame_t f;

  assign f         = frame_t'(frame);
  assign status    = f.eoc;
  assign sign      = f.sign;
  assign value     = f.value;
  assign sub       = f.sub;
  assign frame_err = f.eoc | f.dummy;

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import adc_rd_pkg::*;
#(
  parameter int SCLK_HALF = 4,
  parameter int CFG_W     = 8,
  parameter int POLL_LEN  = 16,
  parameter int GAP_LEN   = 4,
  parameter int TIMEOUT   = 5000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             busy,
  output logic             cs_n,
  output logic             sclk,
  output logic             mosi,
  input  logic             miso,
  output logic             res_valid,
  output logic             res_status,
  output logic             res_sign,
  output logic [VAL_W-1:0] res_value,
  output logic [SUB_W-1:0] res_sub,
  output logic             res_frame_err,
  output logic             timeout_err
);

  localparam int WIN_MAX = (POLL_LEN > GAP_LEN) ? POLL_LEN : GAP_LEN;
  localparam int WIN_W   = $clog2(WIN_MAX + 1);
  localparam int TMO_W   = $clog2(TIMEOUT + 1);

  rd_state_e            st_q;
  logic [WIN_W-1:0]     win_q;
  logic [TMO_W-1:0]     tmo_q;
  logic                 cs_q;
  logic                 busy_q;
  logic                 valid_q;
  logic                 tout_q;
  logic [CFG_W-1:0]     cfg_q;
  logic [FRAME_W-1:0]   frame_q;

  logic                 polling;
  logic                 tmo_hit;
  logic                 ready_hit;
  logic                 load;
  logic                 run;
  logic                 rise;
  logic                 fall;
  logic                 last_fall;
  logic [FRAME_W-1:0]   rx;

  assign polling   = (st_q == ST_POLL) || (st_q == ST_GAP);
  assign tmo_hit   = polling && (tmo_q == TMO_W'(TIMEOUT - 1));
  assign ready_hit = (st_q == ST_POLL) && (win_q != '0) && !miso;
  assign load      = ready_hit && !tmo_hit;
  assign run       = (st_q == ST_SHIFT);

  adc_rd_sclk #(.HALF(SCLK_HALF)) u_sclk (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (run),
    .sclk (sclk),
    .rise (rise),
    .fall (fall)
  );

  adc_rd_shift #(.FW(FRAME_W), .CFG_W(CFG_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .cfg      (cfg_q),
    .rise     (rise),
    .fall     (fall),
    .miso     (miso),
    .mosi     (mosi),
    .rx       (rx),
    .last_fall(last_fall)
  );

  adc_rd_unpack u_unpack (
    .frame    (frame_q),
    .status   (res_status),
    .sign     (res_sign),
    .value    (res_value),
    .sub      (res_sub),
    .frame_err(res_frame_err)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      win_q   <= '0;
      tmo_q   <= '0;
      cs_q    <= 1'b1;
      busy_q  <= 1'b0;
      valid_q <= 1'b0;
      tout_q  <= 1'b0;
      cfg_q   <= '0;
      frame_q <= '0;
    end else begin
      valid_q <= 1'b0;
      tout_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q   <= ST_POLL;
            cs_q   <= 1'b0;
            busy_q <= 1'b1;
            win_q  <= '0;
            tmo_q  <= '0;
            cfg_q  <= cfg_word;
          end
        end
        ST_POLL: begin
          tmo_q <= tmo_q + 1'b1;
          if (tmo_hit) begin
            st_q   <= ST_IDLE;
            cs_q   <= 1'b1;
            busy_q <= 1'b0;
            tout_q <= 1'b1;
          end else if (ready_hit) begin
            st_q  <= ST_SHIFT;
            win_q <= '0;
          end else if (win_q == WIN_W'(POLL_LEN - 1)) begin
            st_q  <= ST_GAP;
            cs_q  <= 1'b1;
            win_q <= '0;
          end else begin
            win_q <= win_q + 1'b1;
          end
        end
        ST_GAP: begin
          tmo_q <= tmo_q + 1'b1;
          if (tmo_hit) begin
            st_q   <= ST_IDLE;
            busy_q <= 1'b0;
            tout_q <= 1'b1;
          end else if (win_q == WIN_W'(GAP_LEN - 1)) begin
            st_q  <= ST_POLL;
            cs_q  <= 1'b0;
            win_q <= '0;
          end else begin
            win_q <= win_q + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (last_fall) begin
            st_q    <= ST_DONE;
            cs_q    <= 1'b1;
            valid_q <= 1'b1;
            frame_q <= rx;
          end
        end
        ST_DONE: begin
          st_q   <= ST_IDLE;
          busy_q <= 1'b0;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n        = cs_q;
  assign busy        = busy_q;
  assign res_valid   = valid_q;
  assign timeout_err = tout_q;

  // R4: serial clock held low while deselected
  p_sclk_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cs_q |-> !sclk);

  // R2: deselected whenever not busy
  p_idle_desel_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> cs_q);

  // R6: configuration bit steady at the converter's sampling edge
  p_mosi_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sclk) |-> $stable(mosi));

  // R9: result strobe lasts one cycle and busy follows it down
  p_valid_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (!res_valid && !busy_q));

  // R10: timeout never coincides with a result and ends the read
  p_timeout_r10: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_err |-> (!res_valid && !busy_q && cs_q));

endmodule

// File: tb/tb_adc_frame_reader.sv
module tb_adc_frame_reader;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;
  localparam int CFGW       = 8;
  localparam int PLEN       = 12;
  localparam int GLEN       = 4;
  localparam int TMO        = 400;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [CFGW-1:0] cfg_word = '0;
  logic            busy, cs_n, sclk, mosi, miso;
  logic            res_valid, res_status, res_sign, res_frame_err, timeout_err;
  logic [23:0]     res_value;
  logic [4:0]      res_sub;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_frame_reader #(
    .SCLK_HALF(HALF), .CFG_W(CFGW), .POLL_LEN(PLEN), .GAP_LEN(GLEN), .TIMEOUT(TMO)
  ) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_word(cfg_word), .busy(busy),
    .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso), .res_valid(res_valid),
    .res_status(res_status), .res_sign(res_sign), .res_value(res_value),
    .res_sub(res_sub), .res_frame_err(res_frame_err), .timeout_err(timeout_err)
  );

  int errors = 0;
  int checks = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- converter model ----------------
  logic [31:0] frame_q = '0;
  logic        glitch = 1'b0;
  int          conv_len = 30;
  logic        ready;
  int          conv_left;
  int          falls;
  int          lowcnt;
  logic        sclk_d, cs_d;
  logic [31:0] cfg_rx;

  assign miso = cs_n ? 1'b1 :
                (!ready ? 1'b1 :
                 (falls >= 32 ? 1'b0 :
                  (falls == 0 ? ((glitch && lowcnt >= 2) | frame_q[31]) : frame_q[31 - falls])));

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0; conv_left <= conv_len; falls <= 0; lowcnt <= 0;
      sclk_d <= 1'b0; cs_d <= 1'b1; cfg_rx <= '0;
    end else begin
      sclk_d <= sclk;
      cs_d   <= cs_n;
      if (cs_n) lowcnt <= 0;
      else if (ready) lowcnt <= lowcnt + 1;
      if (sclk && !sclk_d) cfg_rx <= {cfg_rx[30:0], mosi};
      if (!sclk && sclk_d && falls < 32) falls <= falls + 1;
      if (cs_n && !cs_d) begin
        if (falls == 32 || (falls == 31 && !sclk && sclk_d)) begin
          ready <= 1'b0; conv_left <= conv_len;
        end
        falls <= 0;
      end else if (!ready) begin
        if (conv_left <= 1) ready <= 1'b1;
        else conv_left <= conv_left - 1;
      end
    end
  end

  // ---------------- per-clock reference checks ----------------
  logic [31:0] exp_frame = '0;
  logic [7:0]  exp_cfg = '0;
  int n_valid = 0, n_tout = 0;
  int hi_run = 0, rise_cnt = 0, low_run = 0, gap_run = 0, busy_cyc = 0;
  logic p_sclk = 0, p_cs = 1, p_busy = 0, p_valid = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      chk(!(cs_n && sclk), "R4 sclk low when deselected", sclk, 0);
      chk(busy || cs_n, "R2 deselected when idle", cs_n, 1);
      if (sclk) hi_run++;
      else if (p_sclk) begin
        chk(hi_run == HALF, "R5 sclk high phase", hi_run, HALF);
        hi_run = 0;
      end
      if (sclk && !p_sclk) rise_cnt++;
      if (cs_n && !p_cs) begin
        if (rise_cnt > 0) chk(rise_cnt == 32, "R4 rising edges per frame", rise_cnt, 32);
        else if (busy) chk(low_run == PLEN, "R3 poll window length", low_run, PLEN);
        rise_cnt = 0; low_run = 0;
      end
      if (!cs_n) low_run++;
      if (!busy) gap_run = 0;
      else if (cs_n) gap_run++;
      else if (p_cs && gap_run > 0) begin
        chk(gap_run == GLEN, "R3 gap length", gap_run, GLEN);
        gap_run = 0;
      end
      if (busy) busy_cyc = p_busy ? busy_cyc + 1 : 1;
      if (p_valid) chk(!busy && !res_valid, "R9 busy drops after strobe", {busy, res_valid}, 0);
      if (res_valid) begin
        n_valid++;
        chk(cs_n && busy, "R9 deselected at strobe", {cs_n, busy}, 3);
        chk(res_status == exp_frame[31], "R7 status bit", res_status, exp_frame[31]);
        chk(res_sign == exp_frame[29], "R7 sign bit", res_sign, exp_frame[29]);
        chk(res_value == exp_frame[28:5], "R7 value field", res_value, exp_frame[28:5]);
        chk(res_sub == exp_frame[4:0], "R7 sub field", res_sub, exp_frame[4:0]);
        chk(res_frame_err == (exp_frame[31] | exp_frame[30]), "R8 frame error",
            res_frame_err, exp_frame[31] | exp_frame[30]);
        chk(cfg_rx == {exp_cfg, 24'h0}, "R6 config word at converter", cfg_rx, {exp_cfg, 24'h0});
      end
      if (timeout_err) begin
        n_tout++;
        chk(busy_cyc == TMO && !res_valid, "R10 timeout after limit", busy_cyc, TMO);
      end
      p_sclk = sclk; p_cs = cs_n; p_busy = busy; p_valid = res_valid;
    end
  end

  task automatic do_read(input logic [31:0] fr, input logic [7:0] cfg,
                         input bit glt, input bit mid_start);
    int v0, t0, n;
    frame_q   = fr;
    glitch    = glt;
    exp_frame = {glt | fr[31], fr[30:0]};
    exp_cfg   = cfg;
    cfg_word  = cfg;
    v0 = n_valid; t0 = n_tout;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; cfg_word = ~cfg;
    chk(!cs_n && busy, "R2 start selects converter", {cs_n, busy}, 1);
    n = 0;
    while (n_valid == v0 && n_tout == t0 && n < 5000) begin
      @(negedge clk);
      n++;
      if (mid_start && sclk && n > 40) begin start = 1'b1; @(negedge clk); start = 1'b0; mid_start = 0; end
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !res_valid && !timeout_err, "R1 reset state",
        {cs_n, sclk, busy, res_valid, timeout_err}, 5'b10000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n && !sclk && !busy && !res_valid && !timeout_err, "R1 state after reset",
        {cs_n, sclk, busy, res_valid, timeout_err}, 5'b10000);
    for (int i = 0; i < 4; i++) begin
      logic [31:0] fr;
      fr = {1'b0, 1'b0, i[0], 24'(32'h13A5C7 * (i + 3)), 5'(i * 7 + 3)};
      do_read(fr, 8'(8'hA5 + i * 8'h3C), 1'b0, i == 2);
    end
    begin
      int v0;
      v0 = n_valid;
      repeat (80) @(negedge clk);
      chk(n_valid == v0 && !busy && cs_n, "R2 start while busy ignored", {busy, cs_n}, 1);
    end
    do_read({1'b0, 1'b1, 1'b1, 24'hFFFFFF, 5'h1F}, 8'hFF, 1'b0, 1'b0);
    do_read({1'b0, 1'b0, 1'b0, 24'h000001, 5'h00}, 8'h01, 1'b1, 1'b0);
    conv_len = 2;
    repeat (40) @(negedge clk);
    do_read({1'b0, 1'b0, 1'b1, 24'h800000, 5'h10}, 8'h80, 1'b0, 1'b0);
    conv_len = 100000;
    do_read({1'b0, 1'b0, 1'b0, 24'h5A5A5A, 5'h0A}, 8'h3C, 1'b0, 1'b0);
    begin
      int v0, t0;
      v0 = n_valid; t0 = n_tout;
      do_read(32'h0, 8'h00, 1'b0, 1'b0);
      chk(n_tout == t0 + 1 && n_valid == v0, "R10 timeout reported without result",
          n_tout - t0, 1);
      chk(!busy && cs_n, "R10 idle after timeout", {busy, cs_n}, 1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule